// File: doc/BRIEF.md
# Buffered-Compare Timer Counter

A timer/counter core with a plain write-strobe register port. The counter can be 8, 16 or 32 bits wide and counts up or down. Each step comes either from a power-of-two divided version of the core clock or from a single-cycle external event strobe. When the count wraps at its upper limit (TOP) or its lower limit (ZERO), the core emits a one-cycle limit pulse. Two channels each hold a value that is compared with the counter continuously. Each channel pulses its own match output when the counter arrives at that value.

Every channel value has a shadow buffer with a valid flag. In 8-bit mode only, the period value also has a shadow buffer with a valid flag. A pending buffer is copied into its live register at the next wrap, and its flag clears. This lets software change compare points and the period without tearing a cycle. The structural fields of the control word can only be changed while the core is stopped. The start/stop bit and the software reset bit can always be written. All pulses are also collected in sticky status bits. Software clears a status bit by writing a 1 to it.

Top module: `tmr_core`

## Requirements
- R1: Width field ctrl[3:2] selects 0=16-bit (reset default, also used for code 3), 1=8-bit, 2=32-bit. MAX is 2^width-1. Data written to the counter (addr 2) and to the channel registers (addr 3,4,6,7) is truncated to the selected width.
- R2: The counter steps only while enable ctrl[0] is 1. Source bit ctrl[9]=0 steps on prescaler ticks. Source bit ctrl[9]=1 steps once for each clock cycle in which evt_i is high.
- R3: Direction bit ctrl[8]=0 counts up, and a step taken at TOP loads 0. Direction bit ctrl[8]=1 counts down, and a step taken at 0 loads TOP. A wrap step raises top_o for one cycle, in the same cycle as the new count appears.
- R4: A channel's mc_o bit is high for one cycle when a step brings the counter to that channel's live value. The pulse appears in the same cycle as that count.
- R5: Writing a channel buffer (addr 6, 7) or the period buffer (addr 8) sets its bufv_o bit: bit0 for channel 0, bit1 for channel 1, bit2 for the period. At a wrap step, every valid buffer is copied to its live register and its bufv_o bit clears.
- R6: The period register (addr 5) and the period buffer (addr 8) accept writes only in 8-bit mode. In 8-bit mode TOP is the period. In the other modes TOP is MAX.
- R7: While enable is 1, a control write (addr 0) changes only the enable bit. Width, prescale select ctrl[7:4], direction, source and wave ctrl[11:10] keep their values. While enable is 0, all of these fields are writable.
- R8: A control write issued while stopped that also sets enable to 1 applies every field. A write issued while running that clears enable leaves all other fields unchanged.
- R9: Prescale select n (0..10; values above 10 act as 10) gives one tick every 2^n cycles. The prescaler is cleared while the core is stopped and at each wrap step.
- R10: A control write with bit1 set returns every register to its reset value in the next cycle, which includes clearing enable.
- R11: status_o bit0 (wrap) and bits 1 and 2 (channel 0 and channel 1 matches) are set by the pulses and stay set. Writing a 1 to a bit at addr 1 clears it. A set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Write data |
| evt_i | input | 1 | External count event strobe |
| ctrl_o | output | 12 | Current control word |
| cnt_o | output | 32 | Counter value |
| cc_o | output | 64 | Live channel values, channel 0 in the low word |
| per_o | output | 8 | Live period value |
| bufv_o | output | 3 | Buffer valid flags |
| top_o | output | 1 | Wrap pulse |
| mc_o | output | 2 | Channel match pulses |
| status_o | output | 3 | Sticky status bits |

## Verification
A wrong buffer valid flag or a stale shadow value does not show at the moment it is written. It shows at the next wrap, as a wrong cc_o or per_o value and a bufv_o bit that does not clear. In 8-bit mode it also shows one period later, as a wrap at the wrong count. A wrong prescaler phase or a wrong limit compare moves both cnt_o and top_o by whole ticks, so the bench samples them on exact cycles. A leak through the enable protection shows at once on ctrl_o, in the cycle after the write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    W16 = 2'd0,
    W8  = 2'd1,
    W32 = 2'd2
  } width_e;

  typedef struct packed {
    logic [1:0] wave;
    logic       src;
    logic       dir;
    logic [3:0] psel;
    width_e     mode;
    logic       rsv;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_CNT  = 2;
  localparam int A_CC0  = 3;
  localparam int A_PER  = 5;
  localparam int A_CCB0 = 6;
  localparam int A_PERB = 8;

  function automatic logic [31:0] width_mask(width_e m);
    case (m)
      W8:      width_mask = 32'h0000_00FF;
      W32:     width_mask = 32'hFFFF_FFFF;
      default: width_mask = 32'h0000_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic [3:0] sel,
  output logic       tick
);
  logic [PW-1:0] psc_q, psc_d, sel_mask;
  int            sel_c;

  always_comb begin
    sel_c = (int'(sel) > PW) ? PW : int'(sel);
    for (int b = 0; b < PW; b++) sel_mask[b] = (b < sel_c);
    tick  = en && ((psc_q & sel_mask) == sel_mask);
    psc_d = (!en || clr) ? '0 : psc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  AST_PSC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (psc_q == '0)); // R9
endmodule

// File: rtl/tmr_bufreg.sv
module tmr_bufreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         swrst,
  input  logic         act_wr,
  input  logic         buf_wr,
  input  logic [W-1:0] wdata,
  input  logic         upd,
  output logic [W-1:0] act_q,
  output logic         vld_q
);
  logic [W-1:0] buf_q, act_d, buf_d;
  logic         vld_d;

  always_comb begin
    act_d = act_q;
    buf_d = buf_q;
    vld_d = vld_q;
    if (upd && vld_q) begin
      act_d = buf_q;
      vld_d = 1'b0;
    end
    if (act_wr) act_d = wdata;
    if (buf_wr) begin
      buf_d = wdata;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      buf_q <= '0;
      vld_q <= 1'b0;
    end else if (swrst) begin
      act_q <= '0;
      buf_q <= '0;
      vld_q <= 1'b0;
    end else begin
      act_q <= act_d;
      buf_q <= buf_d;
      vld_q <= vld_d;
    end
  end

  AST_UPD_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !buf_wr) |=> !vld_q); // R5
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swrst,
  input  logic          tick,
  input  logic          dir,
  input  logic [CW-1:0] top,
  input  logic [CW-1:0] mask,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output logic          wrap
);
  logic [CW-1:0] step;

  always_comb begin
    wrap = tick && (dir ? (cnt_q == '0) : (cnt_q == top));
    if (dir) step = wrap ? top : ((cnt_q - 1'b1) & mask);
    else     step = wrap ? '0  : ((cnt_q + 1'b1) & mask);
    cnt_d = cnt_q;
    if (tick) cnt_d = step;
    if (wr)   cnt_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (swrst) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CW  = 32,
  parameter int PW  = 8,
  parameter int NCH = 2,
  parameter int AW  = 4,
  parameter int PSW = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    evt_i,
  output logic [tmr_pkg::CTRL_W-1:0] ctrl_o,
  output logic [CW-1:0]           cnt_o,
  output logic [NCH*CW-1:0]       cc_o,
  output logic [PW-1:0]           per_o,
  output logic [NCH:0]            bufv_o,
  output logic                    top_o,
  output logic [NCH-1:0]          mc_o,
  output logic [NCH:0]            status_o
);
  import tmr_pkg::*;

  ctrl_t           ctrl_q, ctrl_d;
  logic            ctrl_wr, swrst, is8, psc_tick, tick, wrap;
  logic [CW-1:0]   mask, top, wdat_m, cnt_q, cnt_d;
  logic [PW-1:0]   per_q;
  logic            per_vld;
  logic [NCH-1:0]  mc_d, mc_q, ch_vld;
  logic            top_q;
  logic [NCH:0]    stat_q, stat_d, stat_clr;

  assign ctrl_wr = wr_en && (wr_addr == AW'(A_CTRL));
  assign swrst   = ctrl_wr && wr_data[1];
  assign is8     = (ctrl_q.mode == W8);
  assign mask    = CW'(width_mask(ctrl_q.mode));
  assign wdat_m  = wr_data & mask;
  assign top     = is8 ? CW'(per_q) : mask;
  assign tick    = ctrl_q.en && (ctrl_q.src ? evt_i : psc_tick);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      if (!ctrl_q.en) ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
      else            ctrl_d.en = wr_data[0];
      ctrl_d.rsv = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (swrst) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  tmr_prescale #(.PW(PSW)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .clr(wrap | swrst),
    .sel(ctrl_q.psel), .tick(psc_tick)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .swrst(swrst), .tick(tick), .dir(ctrl_q.dir),
    .top(top), .mask(mask), .wr(wr_en && (wr_addr == AW'(A_CNT))),
    .wdata(wdat_m), .cnt_q(cnt_q), .cnt_d(cnt_d), .wrap(wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cc_act;
    tmr_bufreg #(.W(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .swrst(swrst),
      .act_wr(wr_en && (wr_addr == AW'(A_CC0 + i))),
      .buf_wr(wr_en && (wr_addr == AW'(A_CCB0 + i))),
      .wdata(wdat_m), .upd(wrap), .act_q(cc_act), .vld_q(ch_vld[i])
    );
    assign mc_d[i] = tick && ((cnt_d & mask) == (cc_act & mask));
    assign cc_o[i*CW +: CW] = cc_act;
  end

  tmr_bufreg #(.W(PW)) u_per (
    .clk(clk), .rst_n(rst_n), .swrst(swrst),
    .act_wr(wr_en && is8 && (wr_addr == AW'(A_PER))),
    .buf_wr(wr_en && is8 && (wr_addr == AW'(A_PERB))),
    .wdata(wr_data[PW-1:0]), .upd(wrap), .act_q(per_q), .vld_q(per_vld)
  );

  always_comb begin
    stat_clr = (wr_en && (wr_addr == AW'(A_STAT))) ? wr_data[NCH:0] : '0;
    stat_d   = (stat_q & ~stat_clr) | {mc_d, wrap};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mc_q   <= '0;
      top_q  <= 1'b0;
    end else if (swrst) begin
      stat_q <= '0;
      mc_q   <= '0;
      top_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mc_q   <= mc_d;
      top_q  <= wrap;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign cnt_o    = cnt_q;
  assign per_o    = per_q;
  assign bufv_o   = {per_vld, ch_vld};
  assign top_o    = top_q;
  assign mc_o     = mc_q;
  assign status_o = stat_q;

  AST_PROT_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && ctrl_wr && !wr_data[1]) |=> $stable(ctrl_q[CTRL_W-1:2])); // R7
  AST_SWRST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (ctrl_q == '0)); // R10
  AST_IDLE_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !wr_en) |=> $stable(cnt_q)); // R2
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    top_q |-> stat_q[0]); // R11
endmodule

// File: tb/sim_tmr_core.sv
module sim_tmr_core;
  localparam int K_CNT = 0, K_TOP = 1, K_MC0 = 2, K_MC1 = 3, K_STAT = 4,
                 K_BUFV = 5, K_CC0 = 6, K_CC1 = 7, K_PER = 8, K_CTRL = 9;

  typedef struct {
    int          cyc;
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk, rst_n, wr_en, evt_i;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [11:0] ctrl_o;
  logic [31:0] cnt_o;
  logic [63:0] cc_o;
  logic [7:0]  per_o;
  logic [2:0]  bufv_o, status_o;
  logic        top_o;
  logic [1:0]  mc_o;

  item_t       sq[$];
  item_t       it;
  logic [31:0] act;
  int          ncyc = 0, total = 0, bad = 0;
  bit          done = 0;

  tmr_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_i(evt_i), .ctrl_o(ctrl_o), .cnt_o(cnt_o), .cc_o(cc_o), .per_o(per_o),
    .bufv_o(bufv_o), .top_o(top_o), .mc_o(mc_o), .status_o(status_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) ncyc++;

  function automatic logic [31:0] sample(int kind);
    case (kind)
      K_CNT:   return cnt_o;
      K_TOP:   return 32'(top_o);
      K_MC0:   return 32'(mc_o[0]);
      K_MC1:   return 32'(mc_o[1]);
      K_STAT:  return 32'(status_o);
      K_BUFV:  return 32'(bufv_o);
      K_CC0:   return cc_o[31:0];
      K_CC1:   return cc_o[63:32];
      K_PER:   return 32'(per_o);
      default: return 32'(ctrl_o);
    endcase
  endfunction

  always @(negedge clk) begin
    while (sq.size() > 0 && sq[0].cyc == ncyc) begin
      it  = sq.pop_front();
      act = sample(it.kind);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_in(int d, int kind, logic [31:0] v, string req);
    item_t e;
    e.cyc = ncyc + d; e.kind = kind; e.exp = v; e.req = req;
    sq.push_back(e);
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic evt_pulse();
    evt_i = 1'b1;
    @(negedge clk);
    evt_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; evt_i = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // reset state, default width 16 (R1)
    expect_in(1, K_CTRL, 32'h0, "R1 reset ctrl");
    expect_in(1, K_CNT, 32'h0, "R1 reset count");
    expect_in(1, K_STAT, 32'h0, "R11 reset status");
    expect_in(1, K_BUFV, 32'h0, "R5 reset bufv");
    settle(2);

    // plain up count at prescale 1
    wr(0, 32'h001);
    expect_in(5, K_CNT, 32'd5, "R3 up count");
    settle(6);
    wr(0, 32'h005);
    expect_in(1, K_CTRL, 32'h001, "R7 width locked while running");
    settle(2);
    wr(0, 32'h004);
    expect_in(1, K_CTRL, 32'h000, "R8 stop write drops fields");
    settle(2);
    wr(5, 32'd9);
    expect_in(1, K_PER, 32'd0, "R6 period write ignored in 16-bit");
    settle(2);

    // 8-bit mode with period 5
    wr(0, 32'h004);
    expect_in(1, K_CTRL, 32'h004, "R7 fields writable while stopped");
    settle(1);
    wr(5, 32'd5);
    wr(3, 32'd3);
    wr(4, 32'd200);
    wr(2, 32'd0);
    wr(0, 32'h005);
    expect_in(1, K_CTRL, 32'h005, "R8 start write applies fields");
    expect_in(3, K_MC0, 32'd1, "R4 match pulse at value");
    expect_in(4, K_MC0, 32'd0, "R4 match pulse single cycle");
    expect_in(5, K_CNT, 32'd5, "R6 count reaches period");
    expect_in(6, K_CNT, 32'd0, "R6 wrap at period");
    expect_in(6, K_TOP, 32'd1, "R3 wrap pulse");
    expect_in(6, K_STAT, 32'h3, "R11 sticky wrap and match");
    expect_in(7, K_TOP, 32'd0, "R3 wrap pulse single cycle");
    settle(8);
    wr(0, 32'h004);
    settle(1);
    wr(1, 32'h1);
    expect_in(1, K_STAT, 32'h2, "R11 write-one clears bit0 only");
    settle(1);
    wr(1, 32'h2);
    expect_in(1, K_STAT, 32'h0, "R11 clear bit1");
    settle(1);

    // buffered update
    wr(6, 32'd7);
    expect_in(1, K_BUFV, 32'h1, "R5 buffer write sets valid");
    expect_in(1, K_CC0, 32'd3, "R5 live value unchanged before wrap");
    settle(1);
    wr(8, 32'd4);
    wr(2, 32'd0);
    wr(0, 32'h005);
    expect_in(5, K_BUFV, 32'h5, "R5 valid held until wrap");
    expect_in(6, K_BUFV, 32'h0, "R5 valid cleared at wrap");
    expect_in(6, K_CC0, 32'd7, "R5 channel copied at wrap");
    expect_in(6, K_PER, 32'd4, "R5 period copied at wrap");
    expect_in(10, K_CNT, 32'd4, "R6 new period reached");
    expect_in(11, K_CNT, 32'd0, "R6 wrap at new period");
    expect_in(11, K_TOP, 32'd1, "R3 wrap pulse new period");
    settle(12);
    wr(0, 32'h004);
    settle(1);

    // 16-bit down count
    wr(0, 32'h100);
    expect_in(1, K_CTRL, 32'h100, "R7 direction set while stopped");
    settle(1);
    wr(5, 32'd9);
    expect_in(1, K_PER, 32'd4, "R6 period locked outside 8-bit");
    settle(1);
    wr(2, 32'h12345);
    expect_in(1, K_CNT, 32'h2345, "R1 count truncated to 16 bits");
    settle(1);
    wr(2, 32'd2);
    wr(0, 32'h101);
    expect_in(2, K_CNT, 32'd0, "R3 down to zero");
    expect_in(3, K_CNT, 32'hFFFF, "R6 down wrap loads MAX");
    expect_in(3, K_TOP, 32'd1, "R3 wrap pulse at zero");
    settle(4);
    wr(0, 32'h100);
    settle(1);

    // 32-bit up wrap
    wr(0, 32'h008);
    wr(2, 32'hFFFF_FFFE);
    wr(0, 32'h009);
    expect_in(1, K_CNT, 32'hFFFF_FFFF, "R1 32-bit reaches MAX");
    expect_in(2, K_CNT, 32'h0, "R1 32-bit wraps");
    expect_in(2, K_TOP, 32'd1, "R3 wrap pulse 32-bit");
    settle(3);
    wr(0, 32'h008);
    settle(1);

    // prescale divide by 4
    wr(0, 32'h020);
    wr(2, 32'd0);
    wr(0, 32'h021);
    expect_in(3, K_CNT, 32'd0, "R9 no step before 4 cycles");
    expect_in(4, K_CNT, 32'd1, "R9 step at 4 cycles");
    expect_in(7, K_CNT, 32'd1, "R9 hold between ticks");
    expect_in(8, K_CNT, 32'd2, "R9 second tick");
    settle(9);
    wr(0, 32'h020);
    settle(1);

    // event source
    wr(0, 32'h200);
    wr(2, 32'd0);
    wr(0, 32'h201);
    expect_in(3, K_CNT, 32'd0, "R2 no step without events");
    settle(4);
    evt_pulse();
    evt_pulse();
    evt_pulse();
    expect_in(1, K_CNT, 32'd3, "R2 one step per event");
    settle(2);

    // software reset
    wr(7, 32'd9);
    wr(0, 32'h203);
    expect_in(1, K_CTRL, 32'h0, "R10 control cleared");
    expect_in(1, K_CNT, 32'h0, "R10 count cleared");
    expect_in(1, K_BUFV, 32'h0, "R10 buffers cleared");
    expect_in(1, K_CC0, 32'h0, "R10 channel cleared");
    expect_in(1, K_PER, 32'h0, "R10 period cleared");
    expect_in(3, K_CNT, 32'h0, "R10 stopped after reset");
    settle(5);

    while (sq.size() > 0) begin
      it = sq.pop_front();
      total++;
      bad++;
      $display("FAIL %s unchecked actual=none expected=%h", it.req, it.exp);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule